// File: doc/BRIEF.md
# Quasi-Cyclic Syndrome Accumulator

This block forms the syndrome of a received vector for a parity-check code built from two circulant blocks of length `R`. Only one row per block is ever held: a separate rotation engine streams each successive rotated row, one 32-bit word of each half per beat. For row index `z`, the block takes bit `z` of the first received half and bit `z` of the second half. It XORs the matching half-row words into an internal syndrome store. The rows advance for every `z`, whatever the received bits are.

A start pulse clears the store and sets the walk going. The received halves are read one 32-bit word at a time from an external memory with one cycle of read latency, and both halves share one address. After the final word of row `R-1` the block pulses done. The syndrome can be read word by word at any time, and a zero flag reports whether every syndrome word is zero.

Top module: `qcs_syn_acc`

## Requirements
- R1: Out of reset `done_o` and `row_ready_o` are low, every syndrome word reads zero and `syn_zero_o` is high.
- R2: A start pulse accepted while idle clears all syndrome words before the first row word is taken, so no earlier result leaks into the new one.
- R3: Received bit `z` of half 0 (half 1) is bit `z%32` of `rx0_rdata_i` (`rx1_rdata_i`) at address `z/32` on `rx_addr_o`. The read data is taken one cycle after the address is presented.
- R4: For row `z`, the half-0 row word is XORed into the syndrome only when half-0 bit `z` is 1, and the half-1 row word only when half-1 bit `z` is 1. Otherwise the syndrome is unchanged.
- R5: All `R` rows of `W = ceil(R/32)` words are consumed even when every received bit is 0. The syndrome is then zero.
- R6: Row words are taken only on cycles where `row_ready_o` and `row_valid_i` are both high. Word `k` of a row updates syndrome word `k`, and exactly `W` words make one row.
- R7: A cycle with `row_ready_o` high and `row_valid_i` low takes no word and leaves the syndrome unchanged. A stalled stream gives the same result as an unstalled one.
- R8: Syndrome bits at positions `R` and above in the last word always read 0, even when the row words carry ones there.
- R9: `done_o` is high for exactly one cycle, the cycle after the final word of row `R-1` is taken. `syn_zero_o` is high exactly when every syndrome word is zero.
- R10: A start pulse while a run is in progress is ignored.
- R11: `syn_rdata_o` returns syndrome word `syn_addr_i` in the same cycle; bit `b` is syndrome bit `32*syn_addr_i+b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| rx_addr_o | output | K_W | Word address into both received-vector halves |
| rx0_rdata_i | input | 32 | Received half 0 word, one cycle after address |
| rx1_rdata_i | input | 32 | Received half 1 word, one cycle after address |
| row_valid_i | input | 1 | Row stream beat valid |
| row_ready_o | output | 1 | Block ready to take a row word |
| row0_word_i | input | 32 | Current word of rotated half-0 row |
| row1_word_i | input | 32 | Current word of rotated half-1 row |
| syn_addr_i | input | K_W | Syndrome read address |
| syn_rdata_o | output | 32 | Syndrome word at syn_addr_i |
| done_o | output | 1 | One-cycle pulse at end of run |
| syn_zero_o | output | 1 | All syndrome words are zero |

## Verification
The bench builds the block with `R = 67`, so each half spans three words and the last word has 29 padding bits. This short length makes full runs cheap. Every row index crosses two received-word fetch boundaries, and the partial last word exposes the padding mask. With `R` being neither a multiple of 32 nor a power of two, off-by-one errors in the row-end and run-end counters change the done timing or the result.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALVES = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_ACC,
    ST_DONE
  } state_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/qcs_ctrl.sv
module qcs_ctrl
  import qcs_pkg::*;
#(
  parameter int unsigned R   = 4801,
  parameter int unsigned W   = (R + WORD_W - 1) / WORD_W,
  parameter int unsigned K_W = cnt_w(W),
  parameter int unsigned Z_W = cnt_w(R)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           row_valid_i,
  output logic           clear_o,
  output logic           load_o,
  output logic           acc_o,
  output logic [K_W-1:0] word_idx_o,
  output logic [4:0]     bit_idx_o,
  output logic [K_W-1:0] rx_addr_o,
  output logic           row_ready_o,
  output logic           done_o
);
  state_e         state_q;
  logic [Z_W-1:0] z_q;
  logic [K_W-1:0] k_q;
  logic [31:0]    z_ext;
  logic           last_word, last_row;

  assign z_ext       = 32'(z_q);
  assign last_word   = (k_q == K_W'(W - 1));
  assign last_row    = (z_q == Z_W'(R - 1));
  assign bit_idx_o   = z_ext[4:0];
  assign rx_addr_o   = K_W'(z_ext >> 5);
  assign word_idx_o  = k_q;
  assign clear_o     = (state_q == ST_IDLE) && start_i;
  assign load_o      = (state_q == ST_LOAD);
  assign row_ready_o = (state_q == ST_ACC);
  assign acc_o       = row_ready_o && row_valid_i;
  assign done_o      = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      z_q     <= '0;
      k_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          z_q     <= '0;
          k_q     <= '0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD:  state_q <= ST_ACC;
        ST_ACC: if (row_valid_i) begin
          if (last_word) begin
            k_q <= '0;
            if (last_row) begin
              state_q <= ST_DONE;
            end else begin
              z_q <= z_q + 1'b1;
              // next row starts a new received word
              if (z_ext[4:0] == 5'd31) state_q <= ST_FETCH;
            end
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qcs_bitsel.sv
module qcs_bitsel
  import qcs_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  word_t [HALVES-1:0]       rdata_i,
  input  logic  [4:0]              bit_idx_i,
  output logic  [HALVES-1:0]       bits_o
);
  for (genvar g = 0; g < HALVES; g++) begin : g_half
    word_t rx_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rx_q <= '0;
      else if (load_i) rx_q <= rdata_i[g];
    end
    assign bits_o[g] = rx_q[bit_idx_i];
  end
endmodule

// File: rtl/qcs_synmem.sv
module qcs_synmem
  import qcs_pkg::*;
#(
  parameter int unsigned R   = 4801,
  parameter int unsigned W   = (R + WORD_W - 1) / WORD_W,
  parameter int unsigned K_W = cnt_w(W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               acc_i,
  input  logic [K_W-1:0]     word_idx_i,
  input  logic [HALVES-1:0]  bits_i,
  input  word_t [HALVES-1:0] row_i,
  input  logic [K_W-1:0]     rd_addr_i,
  output word_t              rd_data_o,
  output logic               zero_o
);
  localparam int unsigned REM = R % WORD_W;

  word_t syn_w [W];
  word_t contrib;

  always_comb begin
    contrib = '0;
    for (int h = 0; h < HALVES; h++) begin
      contrib = contrib ^ (row_i[h] & {WORD_W{bits_i[h]}});
    end
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_word
    localparam word_t MSK = (gi == W - 1 && REM != 0) ?
                            word_t'((64'd1 << REM) - 64'd1) : {WORD_W{1'b1}};
    word_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '0;
      else if (clear_i)                              q <= '0;
      else if (acc_i && word_idx_i == K_W'(gi))      q <= q ^ (contrib & MSK);
    end
    assign syn_w[gi] = q;
  end

  always_comb begin
    rd_data_o = '0;
    zero_o    = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (rd_addr_i == K_W'(i)) rd_data_o = syn_w[i];
      if (syn_w[i] != '0)       zero_o    = 1'b0;
    end
  end
endmodule

// File: rtl/qcs_syn_acc.sv
module qcs_syn_acc
  import qcs_pkg::*;
#(
  parameter  int unsigned R   = 4801,
  localparam int unsigned W   = (R + WORD_W - 1) / WORD_W,
  localparam int unsigned K_W = cnt_w(W),
  localparam int unsigned Z_W = cnt_w(R)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output logic [K_W-1:0] rx_addr_o,
  input  logic [31:0]    rx0_rdata_i,
  input  logic [31:0]    rx1_rdata_i,
  input  logic           row_valid_i,
  output logic           row_ready_o,
  input  logic [31:0]    row0_word_i,
  input  logic [31:0]    row1_word_i,
  input  logic [K_W-1:0] syn_addr_i,
  output logic [31:0]    syn_rdata_o,
  output logic           done_o,
  output logic           syn_zero_o
);
  logic               clear, load, acc;
  logic [K_W-1:0]     word_idx;
  logic [4:0]         bit_idx;
  logic [HALVES-1:0]  rx_bits;
  word_t [HALVES-1:0] rx_words, row_words;

  assign rx_words  = {rx1_rdata_i, rx0_rdata_i};
  assign row_words = {row1_word_i, row0_word_i};

  qcs_ctrl #(.R(R), .W(W), .K_W(K_W), .Z_W(Z_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .row_valid_i,
    .clear_o(clear), .load_o(load), .acc_o(acc),
    .word_idx_o(word_idx), .bit_idx_o(bit_idx),
    .rx_addr_o, .row_ready_o, .done_o
  );

  qcs_bitsel u_bitsel (
    .clk_i, .rst_ni, .load_i(load), .rdata_i(rx_words),
    .bit_idx_i(bit_idx), .bits_o(rx_bits)
  );

  qcs_synmem #(.R(R), .W(W), .K_W(K_W)) u_synmem (
    .clk_i, .rst_ni, .clear_i(clear), .acc_i(acc),
    .word_idx_i(word_idx), .bits_i(rx_bits), .row_i(row_words),
    .rd_addr_i(syn_addr_i), .rd_data_o(syn_rdata_o), .zero_o(syn_zero_o)
  );
endmodule

// File: rtl/qcs_syn_acc_chk.sv
module qcs_syn_acc_chk #(
  parameter int unsigned R   = 4801,
  parameter int unsigned W   = 151,
  parameter int unsigned K_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [K_W-1:0] rx_addr_o,
  input logic           row_valid_i,
  input logic           row_ready_o,
  input logic [K_W-1:0] syn_addr_i,
  input logic [31:0]    syn_rdata_o,
  input logic           done_o,
  input logic           syn_zero_o
);
  localparam int unsigned REM = R % 32;
  localparam logic [31:0] LAST_MSK = (REM != 0) ? 32'((64'd1 << REM) - 64'd1) : 32'hffff_ffff;

  p_ready_not_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_ready_o |-> !done_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(row_ready_o && row_valid_i));

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_ready_o && !row_valid_i) ##1 $stable(syn_addr_i) |-> $stable(syn_rdata_o));

  p_pad_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_addr_i == K_W'(W - 1)) |-> ((syn_rdata_o & ~LAST_MSK) == 32'd0));

  p_rx_addr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_ready_o |-> (rx_addr_o < K_W'(W)));

  p_busy_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_ready_o && start_i) |=> !done_o || $past(row_valid_i));

  p_zero_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_zero_o && $stable(syn_addr_i) && !row_ready_o) |=> (syn_rdata_o == 32'd0) || !syn_zero_o);
endmodule

bind qcs_syn_acc qcs_syn_acc_chk #(.R(R), .W(W), .K_W(K_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rx_addr_o(rx_addr_o),
  .row_valid_i(row_valid_i), .row_ready_o(row_ready_o), .syn_addr_i(syn_addr_i),
  .syn_rdata_o(syn_rdata_o), .done_o(done_o), .syn_zero_o(syn_zero_o)
);

// File: tb/qcs_syn_acc_tb.sv
module qcs_syn_acc_tb;
  localparam int R   = 67;
  localparam int W   = (R + 31) / 32;
  localparam int K_W = (W > 1) ? $clog2(W) : 1;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [K_W-1:0] rx_addr_o;
  logic [31:0]    rx0_rdata_i = '0, rx1_rdata_i = '0;
  logic           row_valid_i = 1'b0;
  logic           row_ready_o;
  logic [31:0]    row0_word_i = '0, row1_word_i = '0;
  logic [K_W-1:0] syn_addr_i = '0;
  logic [31:0]    syn_rdata_o;
  logic           done_o, syn_zero_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] rxm0 [W];
  logic [31:0] rxm1 [W];

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (int'(rx_addr_o) < W) begin
      rx0_rdata_i <= rxm0[rx_addr_o];
      rx1_rdata_i <= rxm1[rx_addr_o];
    end
  end

  qcs_syn_acc #(.R(R)) u_dut (
    .clk_i, .rst_ni, .start_i, .rx_addr_o, .rx0_rdata_i, .rx1_rdata_i,
    .row_valid_i, .row_ready_o, .row0_word_i, .row1_word_i,
    .syn_addr_i, .syn_rdata_o, .done_o, .syn_zero_o
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [R-1:0] rotv(input logic [R-1:0] h, input int z);
    logic [R-1:0] v;
    for (int i = 0; i < R; i++) v[i] = h[(i + z) % R];
    return v;
  endfunction

  function automatic logic [31:0] row_word(input logic [R-1:0] h, input int z, input int k, input bit pad);
    logic [R-1:0] v;
    logic [31:0]  w;
    v = rotv(h, z);
    for (int b = 0; b < 32; b++) w[b] = (k * 32 + b < R) ? v[k * 32 + b] : pad;
    return w;
  endfunction

  task automatic run_case(input string tag, input logic [R-1:0] x0, input logic [R-1:0] x1,
                          input logic [R-1:0] h0, input logic [R-1:0] h1,
                          input bit stall, input bit pad, input bit mid);
    logic [W*32-1:0] exp;
    int z, k, acc_n, cyc;
    exp = '0;
    for (int i = 0; i < W; i++) begin
      rxm0[i] = '0;
      rxm1[i] = '0;
    end
    for (int i = 0; i < R; i++) begin
      rxm0[i / 32][i % 32] = x0[i];
      rxm1[i / 32][i % 32] = x1[i];
      if (x0[i]) exp[R-1:0] = exp[R-1:0] ^ rotv(h0, i);
      if (x1[i]) exp[R-1:0] = exp[R-1:0] ^ rotv(h1, i);
    end
    z = 0; k = 0; acc_n = 0; cyc = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    while (acc_n < R * W && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
      start_i = mid && (cyc == 20);
      if (done_o) check(1'b0, {"R9 early done ", tag}, 32'(acc_n), 32'(R * W));
      if (row_ready_o && !(stall && (cyc % 3 == 1))) begin
        row_valid_i = 1'b1;
        row0_word_i = row_word(h0, z, k, pad);
        row1_word_i = row_word(h1, z, k, pad);
        acc_n++;
        if (k == W - 1) begin k = 0; z++; end
        else k++;
      end else begin
        row_valid_i = 1'b0;
        row0_word_i = 32'hdead_beef;
        row1_word_i = 32'hcafe_f00d;
      end
    end
    check(cyc < 5000, {"R5 R6 all row words taken ", tag}, 32'(acc_n), 32'(R * W));
    @(negedge clk_i);
    start_i = 1'b0;
    row_valid_i = 1'b0;
    check(done_o == 1'b1, {"R9 done after last word ", tag}, 32'(done_o), 32'd1);
    check(row_ready_o == 1'b0, {"R6 ready low at done ", tag}, 32'(row_ready_o), 32'd0);
    @(negedge clk_i);
    check(done_o == 1'b0, {"R9 done one cycle ", tag}, 32'(done_o), 32'd0);
    for (int i = 0; i < W; i++) begin
      syn_addr_i = K_W'(i);
      #1;
      check(syn_rdata_o == exp[i*32 +: 32], {"R4 R11 syndrome word ", tag}, syn_rdata_o, exp[i*32 +: 32]);
    end
    check(syn_zero_o == (exp == '0), {"R9 zero flag ", tag}, 32'(syn_zero_o), 32'(exp == '0));
  endtask

  task automatic t_reset();
    check(done_o == 1'b0, "R1 done after reset", 32'(done_o), 32'd0);
    check(row_ready_o == 1'b0, "R1 ready after reset", 32'(row_ready_o), 32'd0);
    check(syn_zero_o == 1'b1, "R1 zero flag after reset", 32'(syn_zero_o), 32'd1);
    for (int i = 0; i < W; i++) begin
      syn_addr_i = K_W'(i);
      #1;
      check(syn_rdata_o == 32'd0, "R1 syndrome after reset", syn_rdata_o, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [R-1:0] h0, h1, xa0, xa1, zero_v, ones_v, xs0, xs1;
    h0 = '0; h1 = '0; xa0 = '0; xa1 = '0; zero_v = '0; ones_v = '1;
    h0[0] = 1'b1; h0[5] = 1'b1; h0[31] = 1'b1; h0[32] = 1'b1; h0[66] = 1'b1;
    h1[3] = 1'b1; h1[40] = 1'b1; h1[64] = 1'b1;
    for (int i = 0; i < R; i++) begin
      xa0[i] = (i % 3 == 0);
      xa1[i] = (i % 5 == 1);
    end
    xs0 = '0; xs1 = '0;
    xs0[R-1] = 1'b1;
    xs1[32] = 1'b1;
    for (int i = 0; i < W; i++) begin
      rxm0[i] = '0;
      rxm1[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 R4: mixed pattern on both halves
    run_case("mixed", xa0, xa1, h0, h1, 1'b0, 1'b0, 1'b0);
    // R2 R5: all-zero vector after a nonzero result must give zero
    run_case("all zero", zero_v, zero_v, h0, h1, 1'b0, 1'b0, 1'b0);
    // R4: only half 0, then only half 1
    run_case("half0 only", xa0, zero_v, h0, h1, 1'b0, 1'b0, 1'b0);
    run_case("half1 only", zero_v, xa1, h0, h1, 1'b0, 1'b0, 1'b0);
    // R3: last row and a word-boundary row
    run_case("boundary bits", xs0, xs1, h0, h1, 1'b0, 1'b0, 1'b0);
    // R7: stalled stream
    run_case("stalled", xa0, xa1, h0, h1, 1'b1, 1'b0, 1'b0);
    // R8: junk in padding positions of row words
    run_case("pad junk", xa0, xa1, h0, h1, 1'b0, 1'b1, 1'b0);
    // R10: start pulse during a run
    run_case("busy start", xa0, xa1, h0, h1, 1'b0, 1'b0, 1'b1);
    // R9: full activity that cancels to zero
    run_case("cancel", ones_v, ones_v, h0, h0, 1'b0, 1'b1, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule